// File: doc/BRIEF.md
# SECDED Memory ECC with First-Error Capture

This block sits between a memory controller and DRAM. Every word written toward memory gets eight check bits from an extended Hamming code over 64 data bits. Every word read back is checked against its stored check bits. A read with one flipped bit, in the data or in the check bits, is returned corrected. A read with two flipped bits, or with a pattern that no single flip explains, is returned unchanged with a poison flag, and its raw check bits are passed along.

Two capture registers record errors for software. One holds the first correctable error and the other holds the first uncorrectable error. Each holds the read address, the syndrome and the stored check bits. The correctable register also holds the decoded position of the failing bit. Later errors of the same class leave the capture alone and set a sticky "more" flag. One clear pulse empties both registers and re-arms them.

For diagnostics, the check bits sent to memory can be XORed with a programmable mask. This stores a word with one or two deliberately wrong bits.

Top module: `ecc_secded_top`

## Requirements
- R1: `wr_check` is combinational from `wr_data`. Data bits take the Hamming positions 3, 5, 6, 7, 9, … in increasing order, skipping powers of two, so bit 0 sits at position 3 and bit 63 at position 71. Check bit j (j = 0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R2: A read presented with `rd_valid` high produces `rsp_valid` high on the next cycle. A clean word is returned unchanged, with `rsp_ce` and `rsp_poison` low.
- R3: When exactly one of the 72 received bits is flipped, `rsp_data` carries the original data and `rsp_ce` is high. This holds for data bits and for check bits.
- R4: Any other non-zero syndrome raises `rsp_poison` and leaves `rsp_ce` low. In that case `rsp_data` equals the received data and `rsp_check` equals the received check bits. On every valid response, `rsp_check` echoes the received check bits.
- R5: Syndrome bits 6..0 are the recomputed check bits 6..0 XORed with the received ones. Syndrome bit 7 is the XOR of all 72 received bits. The bit position is 0..63 for a data bit and 64+k for check bit k.
- R6: The first correctable error after reset or clear sets `ce_valid` and captures the read address, syndrome, received check bits and bit position.
- R7: While `ce_valid` is set, further correctable errors set `ce_more` and leave the captured fields unchanged.
- R8: The first uncorrectable error sets `ue_valid` and captures the address, syndrome and received check bits. Later ones set `ue_more` and leave the capture unchanged.
- R9: A `log_clr` pulse empties both registers. An error read in the same cycle is captured as a new first error.
- R10: With `cfg_inj_en` high, `wr_check` equals the correct check bits XOR `cfg_inj_mask`. With `cfg_inj_en` low, or with a zero mask, `wr_check` is the correct value.
- R11: With `rd_valid` low, the next cycle shows `rsp_valid`, `rsp_ce` and `rsp_poison` low and `rsp_data` zero. Nothing is captured, whatever `rd_data` and `rd_check` carry.
- R12: After reset every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_inj_en | input | 1 | Enables check-bit corruption on writes |
| cfg_inj_mask | input | 8 | XOR mask applied to written check bits |
| wr_data | input | 64 | Data word being written |
| wr_check | output | 8 | Check bits to store with the word |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_addr | input | ADDR_W | Address of the read word |
| rd_data | input | 64 | Data bits read from memory |
| rd_check | input | 8 | Check bits read from memory |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 64 | Corrected data (raw data when poisoned) |
| rsp_check | output | 8 | Received check bits |
| rsp_poison | output | 1 | Uncorrectable error; data is unreliable |
| rsp_ce | output | 1 | A single-bit error was corrected |
| log_clr | input | 1 | Clears and re-arms both capture registers |
| ce_valid | output | 1 | A correctable error is captured |
| ce_more | output | 1 | Further correctable errors occurred |
| ce_addr | output | ADDR_W | Address of the captured correctable error |
| ce_syndrome | output | 8 | Its syndrome |
| ce_check | output | 8 | Its received check bits |
| ce_bitpos | output | 7 | Its failing bit position |
| ue_valid | output | 1 | An uncorrectable error is captured |
| ue_more | output | 1 | Further uncorrectable errors occurred |
| ue_addr | output | ADDR_W | Address of the captured uncorrectable error |
| ue_syndrome | output | 8 | Its syndrome |
| ue_check | output | 8 | Its received check bits |

## Verification
The bench flips data bits at both ends of the word and check bits, including the overall parity bit. A decoder that mishandles the zero-Hamming-syndrome case would report a double error or corrupt data bit 0 instead of repairing check bit 7. Second errors of each class must set only the sticky flag. A design that overwrote the capture would show the later address. A clear in the same cycle as an error must re-arm and then capture, and a design that let the clear win would leave the register empty. Injected masks of weight one and two are written and then read back as a correction and as poison. A zero mask, or the enable held low, must leave the written check bits untouched.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int POS_W  = $clog2(CW_W);

    // Hamming position of data bit idx: positions from 3 upward, powers of two skipped
    function automatic int data_pos(input int idx);
        int n;
        n = 0;
        for (int p = 3; p < (1 << HAM_W); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) return p;
                n++;
            end
        end
        return 0;
    endfunction

    // Data bits that feed Hamming check bit j
    function automatic logic [DATA_W-1:0] col_mask(input int j);
        logic [DATA_W-1:0] m;
        int pos;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos  = data_pos(i);
            m[i] = pos[j];
        end
        return m;
    endfunction

    typedef struct packed {
        logic             ce;
        logic             ue;
        logic [CHK_W-1:0] syn;
        logic [POS_W-1:0] bitpos;
    } ecc_status_t;
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);
    logic [HAM_W-1:0] ham;

    for (genvar j = 0; j < HAM_W; j++) begin : g_col
        localparam logic [DATA_W-1:0] COL = col_mask(j);
        assign ham[j] = ^(data & COL);
    end

    assign check = {^{data, ham}, ham};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  check,
    output logic [DATA_W-1:0] data_fix,
    output ecc_status_t       status
);
    logic [CHK_W-1:0]  recalc;
    logic [HAM_W-1:0]  syn_h;
    logic              par;
    logic              pow2;
    logic              single;
    logic [DATA_W-1:0] hit;

    ecc_enc u_renc (
        .data  (data),
        .check (recalc)
    );

    assign syn_h = recalc[HAM_W-1:0] ^ check[HAM_W-1:0];
    assign par   = ^{data, check};
    assign pow2  = (syn_h != '0) && ((syn_h & (syn_h - 1'b1)) == '0);

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        localparam int P = data_pos(i);
        assign hit[i] = (syn_h == P[HAM_W-1:0]);
    end

    always_comb begin
        single        = par && ((syn_h == '0) || pow2 || (|hit));
        status.ce     = single;
        status.ue     = (par && !single) || (!par && (syn_h != '0));
        status.syn    = {par, syn_h};
        status.bitpos = '0;
        if (syn_h == '0) begin
            status.bitpos = POS_W'(CW_W - 1);
        end else if (pow2) begin
            for (int k = 0; k < HAM_W; k++) begin
                if (syn_h == HAM_W'(1 << k)) status.bitpos = POS_W'(DATA_W + k);
            end
        end else begin
            for (int i = 0; i < DATA_W; i++) begin
                if (hit[i]) status.bitpos = POS_W'(i);
            end
        end
        data_fix = single ? (data ^ hit) : data;
    end
endmodule

// File: rtl/ecc_errlog.sv
module ecc_errlog
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INFO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ev,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [CHK_W-1:0]  ev_syn,
    input  logic [INFO_W-1:0] ev_info,
    output logic              cap_valid,
    output logic              cap_more,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [CHK_W-1:0]  cap_syn,
    output logic [INFO_W-1:0] cap_info
);
    typedef struct packed {
        logic              valid;
        logic              more;
        logic [ADDR_W-1:0] addr;
        logic [CHK_W-1:0]  syn;
        logic [INFO_W-1:0] info;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clr) log_d = '0;
        if (ev) begin
            if (!log_d.valid) begin
                log_d.valid = 1'b1;
                log_d.addr  = ev_addr;
                log_d.syn   = ev_syn;
                log_d.info  = ev_info;
            end else begin
                log_d.more = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign cap_valid = log_q.valid;
    assign cap_more  = log_q.more;
    assign cap_addr  = log_q.addr;
    assign cap_syn   = log_q.syn;
    assign cap_info  = log_q.info;
endmodule

// File: rtl/ecc_secded_top.sv
module ecc_secded_top
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inj_en,
    input  logic [CHK_W-1:0]  cfg_inj_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  wr_check,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CHK_W-1:0]  rsp_check,
    output logic              rsp_poison,
    output logic              rsp_ce,
    input  logic              log_clr,
    output logic              ce_valid,
    output logic              ce_more,
    output logic [ADDR_W-1:0] ce_addr,
    output logic [CHK_W-1:0]  ce_syndrome,
    output logic [CHK_W-1:0]  ce_check,
    output logic [POS_W-1:0]  ce_bitpos,
    output logic              ue_valid,
    output logic              ue_more,
    output logic [ADDR_W-1:0] ue_addr,
    output logic [CHK_W-1:0]  ue_syndrome,
    output logic [CHK_W-1:0]  ue_check
);
    localparam int CE_INFO_W = CHK_W + POS_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  check;
        logic              poison;
        logic              ce;
    } rsp_t;

    logic [CHK_W-1:0]     wr_check_raw;
    logic [DATA_W-1:0]    rd_fix;
    ecc_status_t          st;
    logic [CE_INFO_W-1:0] ce_info;
    rsp_t                 rsp_d, rsp_q;

    // write side: encode, then optional corruption for diagnostics
    ecc_enc u_wenc (
        .data  (wr_data),
        .check (wr_check_raw)
    );
    assign wr_check = wr_check_raw ^ (cfg_inj_en ? cfg_inj_mask : '0);

    // read side: decode and correct
    ecc_dec u_rdec (
        .data     (rd_data),
        .check    (rd_check),
        .data_fix (rd_fix),
        .status   (st)
    );

    always_comb begin
        rsp_d = '0;
        if (rd_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.data   = rd_fix;
            rsp_d.check  = rd_check;
            rsp_d.poison = st.ue;
            rsp_d.ce     = st.ce;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_data   = rsp_q.data;
    assign rsp_check  = rsp_q.check;
    assign rsp_poison = rsp_q.poison;
    assign rsp_ce     = rsp_q.ce;

    ecc_errlog #(.ADDR_W(ADDR_W), .INFO_W(CE_INFO_W)) u_celog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (log_clr),
        .ev        (rd_valid && st.ce),
        .ev_addr   (rd_addr),
        .ev_syn    (st.syn),
        .ev_info   ({rd_check, st.bitpos}),
        .cap_valid (ce_valid),
        .cap_more  (ce_more),
        .cap_addr  (ce_addr),
        .cap_syn   (ce_syndrome),
        .cap_info  (ce_info)
    );
    assign ce_check  = ce_info[CE_INFO_W-1:POS_W];
    assign ce_bitpos = ce_info[POS_W-1:0];

    ecc_errlog #(.ADDR_W(ADDR_W), .INFO_W(CHK_W)) u_uelog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (log_clr),
        .ev        (rd_valid && st.ue),
        .ev_addr   (rd_addr),
        .ev_syn    (st.syn),
        .ev_info   (rd_check),
        .cap_valid (ue_valid),
        .cap_more  (ue_more),
        .cap_addr  (ue_addr),
        .cap_syn   (ue_syndrome),
        .cap_info  (ue_check)
    );
endmodule

// File: rtl/ecc_secded_chk.sv
module ecc_secded_chk
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHK_W-1:0]  rd_check,
    input logic              log_clr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic [CHK_W-1:0]  rsp_check,
    input logic              rsp_poison,
    input logic              rsp_ce,
    input logic              ce_valid,
    input logic              ce_more,
    input logic [ADDR_W-1:0] ce_addr,
    input logic [CHK_W-1:0]  ce_syndrome,
    input logic              ue_valid,
    input logic              ue_more
);
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!rsp_valid && !rsp_ce && !rsp_poison)); // R11
    AST_CE_UE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ce && rsp_poison)); // R4
    AST_POISON_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (!rsp_poison || (rsp_data == $past(rd_data) && rsp_check == $past(rd_check)))); // R4
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && !log_clr) |=> (ce_valid && $stable(ce_addr) && $stable(ce_syndrome))); // R7
    AST_CE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_valid) |-> rsp_ce); // R6
    AST_UE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ue_valid) |-> rsp_poison); // R8
    AST_CE_MORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ce_more |-> ce_valid); // R7
    AST_UE_MORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ue_more |-> ue_valid); // R8
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (log_clr && !rd_valid) |=> (!ce_valid && !ue_valid && !ce_more && !ue_more)); // R9
endmodule

bind ecc_secded_top ecc_secded_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_check    (rd_check),
    .log_clr     (log_clr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_check   (rsp_check),
    .rsp_poison  (rsp_poison),
    .rsp_ce      (rsp_ce),
    .ce_valid    (ce_valid),
    .ce_more     (ce_more),
    .ce_addr     (ce_addr),
    .ce_syndrome (ce_syndrome),
    .ue_valid    (ue_valid),
    .ue_more     (ue_more)
);

// File: tb/tb_ecc_secded_top.sv
`timescale 1ns/1ps
module tb_ecc_secded_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_inj_en = 1'b0;
    logic [7:0]    cfg_inj_mask = '0;
    logic [63:0]   wr_data = '0;
    logic [7:0]    wr_check;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data = '0;
    logic [7:0]    rd_check = '0;
    logic          rsp_valid, rsp_poison, rsp_ce;
    logic [63:0]   rsp_data;
    logic [7:0]    rsp_check;
    logic          log_clr = 1'b0;
    logic          ce_valid, ce_more, ue_valid, ue_more;
    logic [AW-1:0] ce_addr, ue_addr;
    logic [7:0]    ce_syndrome, ce_check, ue_syndrome, ue_check;
    logic [6:0]    ce_bitpos;

    ecc_secded_top #(.ADDR_W(AW)) dut (.*);

    always #2.5 clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_tag = "R12";

    // reference model state
    logic          m_valid, m_poison, m_ce;
    logic [63:0]   m_data;
    logic [7:0]    m_check;
    logic          m_cev, m_cem, m_uev, m_uem;
    logic [AW-1:0] m_cea, m_uea;
    logic [7:0]    m_ces, m_cec, m_ues, m_uec;
    logic [6:0]    m_cep;

    function automatic logic [7:0] m_enc(input logic [63:0] d);
        logic [7:0] c;
        int p;
        c = '0;
        p = 0;
        for (int i = 0; i < 64; i++) begin
            p++;
            while ((p & (p - 1)) == 0) p++;
            for (int j = 0; j < 7; j++) if (p[j]) c[j] = c[j] ^ d[i];
        end
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    function automatic logic [7:0] m_syn(input logic [63:0] d, input logic [7:0] c);
        logic [7:0] e;
        e = m_enc(d);
        return {^{d, c}, e[6:0] ^ c[6:0]};
    endfunction

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        {m_valid, m_poison, m_ce, m_data, m_check} = '0;
        {m_cev, m_cem, m_cea, m_ces, m_cec, m_cep} = '0;
        {m_uev, m_uem, m_uea, m_ues, m_uec} = '0;
    endtask

    // one clock: checks the write encoder, advances the model, compares all outputs
    task automatic step();
        logic [71:0] cw;
        logic [7:0]  s;
        int          kind;
        logic [6:0]  pos;
        logic [63:0] fix;
        #1;
        chk(cfg_inj_en ? "wr_check(R10)" : "wr_check(R1)", wr_check,
            m_enc(wr_data) ^ (cfg_inj_en ? cfg_inj_mask : 8'h00));
        if (log_clr) begin
            {m_cev, m_cem, m_cea, m_ces, m_cec, m_cep} = '0;
            {m_uev, m_uem, m_uea, m_ues, m_uec} = '0;
        end
        {m_valid, m_poison, m_ce, m_data, m_check} = '0;
        if (rd_valid) begin
            s    = m_syn(rd_data, rd_check);
            kind = 0;
            fix  = rd_data;
            pos  = '0;
            if (s != 0) begin
                kind = 2;
                for (int b = 0; b < 72; b++) begin
                    cw = {rd_check, rd_data};
                    cw[b] = ~cw[b];
                    if (m_syn(cw[63:0], cw[71:64]) == 0) begin
                        kind = 1;
                        pos  = 7'(b);
                        fix  = cw[63:0];
                    end
                end
            end
            m_valid  = 1'b1;
            m_data   = fix;
            m_check  = rd_check;
            m_ce     = (kind == 1);
            m_poison = (kind == 2);
            if (kind == 1) begin
                if (!m_cev) begin
                    m_cev = 1'b1; m_cea = rd_addr; m_ces = s; m_cec = rd_check; m_cep = pos;
                end else m_cem = 1'b1;
            end
            if (kind == 2) begin
                if (!m_uev) begin
                    m_uev = 1'b1; m_uea = rd_addr; m_ues = s; m_uec = rd_check;
                end else m_uem = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        chk("rsp_valid", rsp_valid, m_valid);
        chk("rsp_data", rsp_data, m_data);
        chk("rsp_check", rsp_check, m_check);
        chk("rsp_poison", rsp_poison, m_poison);
        chk("rsp_ce", rsp_ce, m_ce);
        chk("ce_valid", ce_valid, m_cev);
        chk("ce_more", ce_more, m_cem);
        chk("ce_addr", ce_addr, m_cea);
        chk("ce_syndrome", ce_syndrome, m_ces);
        chk("ce_check", ce_check, m_cec);
        chk("ce_bitpos", ce_bitpos, m_cep);
        chk("ue_valid", ue_valid, m_uev);
        chk("ue_more", ue_more, m_uem);
        chk("ue_addr", ue_addr, m_uea);
        chk("ue_syndrome", ue_syndrome, m_ues);
        chk("ue_check", ue_check, m_uec);
    endtask

    // read a word with the given codeword bits flipped (flip index 72 = none)
    task automatic rd(input logic [AW-1:0] a, input logic [63:0] d, input int f0, input int f1);
        logic [71:0] cw;
        cw = {m_enc(d), d};
        if (f0 < 72) cw[f0] = ~cw[f0];
        if (f1 < 72) cw[f1] = ~cw[f1];
        rd_valid = 1'b1; rd_addr = a; rd_data = cw[63:0]; rd_check = cw[71:64];
        step();
        rd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        cur_tag = "R12";
        chk("reset rsp", {rsp_valid, rsp_ce, rsp_poison, rsp_data}, '0);
        chk("reset ce", {ce_valid, ce_more, ce_addr, ce_syndrome}, '0);
        chk("reset ue", {ue_valid, ue_more, ue_addr, ue_syndrome}, '0);
        rst_n = 1'b1;

        cur_tag = "R1";
        wr_data = 64'h0;                 step();
        wr_data = '1;                    step();
        wr_data = 64'h0123_4567_89ab_cdef; step();
        wr_data = 64'h8000_0000_0000_0001; step();

        cur_tag = "R2";
        rd(32'h100, 64'hdead_beef_0bad_f00d, 72, 72);
        rd(32'h104, 64'h0, 72, 72);

        cur_tag = "R6";  rd(32'h200, 64'h1234_5678_9abc_def0, 5, 72);
        cur_tag = "R7";  rd(32'h300, 64'hffff_0000_ffff_0000, 63, 72);
        cur_tag = "R3";  rd(32'h304, 64'h5555_aaaa_5555_aaaa, 71, 72);
        cur_tag = "R5";  rd(32'h308, 64'h0f0f_0f0f_f0f0_f0f0, 66, 72);
        cur_tag = "R3";  rd(32'h30c, 64'h1, 0, 72);

        cur_tag = "R8";  rd(32'h400, 64'hcafe_babe_1234_0000, 0, 1);
        cur_tag = "R4";  rd(32'h500, 64'h7777_1111_2222_3333, 10, 67);
        cur_tag = "R4";  rd(32'h504, 64'h0, 70, 71);

        cur_tag = "R11";
        rd_valid = 1'b0; rd_data = 64'h0000_0000_0000_0020; rd_check = 8'h00; rd_addr = 32'hbad;
        step();
        rd_data = '0; rd_check = '0;

        cur_tag = "R9";
        log_clr = 1'b1; step(); log_clr = 1'b0;
        log_clr = 1'b1; rd(32'h600, 64'habcd_ef01_2345_6789, 40, 72); log_clr = 1'b0;
        rd(32'h604, 64'h2, 33, 72);
        log_clr = 1'b1; step(); log_clr = 1'b0;

        cur_tag = "R10";
        cfg_inj_en = 1'b1; cfg_inj_mask = 8'h01; wr_data = 64'h1357_9bdf_2468_ace0; step();
        rd_valid = 1'b1; rd_addr = 32'h700; rd_data = wr_data; rd_check = wr_check; step();
        rd_valid = 1'b0;
        cfg_inj_mask = 8'h03; wr_data = 64'hfedc_ba98_7654_3210; step();
        rd_valid = 1'b1; rd_addr = 32'h704; rd_data = wr_data; rd_check = wr_check; step();
        rd_valid = 1'b0;
        cfg_inj_mask = 8'h00; step();
        cfg_inj_en = 1'b0; cfg_inj_mask = 8'hff; step();
        rd_valid = 1'b1; rd_addr = 32'h708; rd_data = wr_data; rd_check = wr_check; step();
        rd_valid = 1'b0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule